// File: doc/BRIEF.md
# Compressed-Mode Instruction Stream Sequencer

This block sits between instruction fetch and decode. It accepts aligned 32-bit fetch words over a valid/ready handshake, splits each word into two 16-bit parcels, and sends out one decoded slot per instruction over a second valid/ready handshake. A slot is either a full 32-bit standard instruction or a 16-bit compressed instruction. Compressed mode is stored context: an entry parcel, marked by either of two adjacent major opcode values, switches the stream into compressed decoding. A continue bit in every compressed parcel decides whether the parcel after it is also compressed. Because of this, a parcel's width depends on the parcels before it.

For every compressed slot the block also expands the immediate into a sign-extended value of `IMM_W` bits. The compressed-mode flag is visible at all times on a save port. A trap pulse clears the flag, and a restore pulse loads it from a restore port, so a trap handler can keep the context across an exception.

Top module: `cm_seq`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `fetch_ready` is 1 and `save_mode` is 0 (standard mode).
- R2: In standard mode, an upper-half parcel whose bits [15:11] differ from `ENTRY_PREFIX` (default 5'b00010) starts a 32-bit instruction. The whole word is consumed and one slot is sent with `out_is16`=0, `out_raw` equal to the word, `out_major`=word[31:26], and `out_form`, `out_ext` and `out_imm` all zero.
- R3: Parcels of a word are taken upper half (bits [31:16]) first, then lower half (bits [15:0]), and each parcel produces at most one slot.
- R4: In standard mode, a parcel whose bits [15:11] equal `ENTRY_PREFIX` is an entry parcel, at either half. It sends a slot with `out_is16`=1, `out_entry`=1, `out_major`=parcel[15:10], `out_ext`=0, `out_form`={parcel[10],parcel[8]} and `out_raw`={16'h0,parcel}.
- R5: In compressed mode, every parcel is a 16-bit slot with `out_entry`=0, `out_major`=0 and `out_ext`=parcel[15:11]. This holds even when those bits equal `ENTRY_PREFIX`.
- R6: Bit 9 of every compressed parcel (entry or sustained) is the continue bit. A 1 keeps compressed mode for the next parcel. A 0 returns to standard decoding for the next parcel.
- R7: In standard mode, a lower-half parcel that is not an entry parcel is padding. It is discarded and sends no slot.
- R8: Form 2'b00 (add-immediate): `out_imm` is the sign extension of {parcel[7],parcel[2:0]}, with range -8..+7.
- R9: Form 2'b01 (shifted add-immediate): `out_imm` is the sign extension of {parcel[7],parcel[6:0],3'b000}, with range -1024..+1016 in steps of 8.
- R10: Forms 2'b10 and 2'b11: `out_imm` is the sign extension of {parcel[7],parcel[6:0]}, with range -128..+127.
- R11: `save_mode` always shows the current mode, including during the cycle of a trap pulse. After that cycle the mode is standard. No parcel is decoded in a trap cycle.
- R12: A restore pulse with no trap pulse loads `restore_mode` into the mode. No parcel is decoded in that cycle, so the next parcel uses the restored mode.
- R13: While `out_valid` is 1 and `out_ready` is 0, all slot outputs stay stable. Across back-pressure, no parcel is lost or sent twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_data | input | 32 | Aligned fetch word |
| fetch_ready | output | 1 | Sequencer can take a word this cycle |
| out_valid | output | 1 | Slot available |
| out_ready | input | 1 | Consumer takes the slot |
| out_is16 | output | 1 | 1 for a 16-bit compressed slot, 0 for 32-bit |
| out_entry | output | 1 | Slot came from an entry parcel |
| out_form | output | 2 | Compressed form code |
| out_ext | output | 5 | Extra opcode bits of a sustained parcel |
| out_major | output | 6 | Major opcode (32-bit or entry slot) |
| out_imm | output | IMM_W | Sign-extended compressed immediate |
| out_raw | output | 32 | Instruction bits, parcel zero-extended |
| trap_pulse | input | 1 | Trap entry: clear the mode |
| restore_pulse | input | 1 | Load the mode from restore_mode |
| restore_mode | input | 1 | Mode value to restore |
| save_mode | output | 1 | Current mode for the trap handler to save |

## Verification
The stream is tried with plain 32-bit words, entry parcels in the upper half and in the lower half, compressed runs that end inside a word and runs that cross into the next word, and sustained parcels whose top bits look like an entry prefix. Together these separate decisions made by context from decisions made by the parcel alone. Padding after a run that ends in the upper half checks that nothing extra appears. Each form is given immediates at both ends of its range, which separates the three sign-extension widths. Random back-pressure on the output runs throughout. A trap followed by a restore shows that the saved context changes how a word without a prefix is decoded.

// File: rtl/cm_pkg.sv
// Shared types for the compressed-mode sequencer.
// Assumes 32-bit fetch words made of two 16-bit parcels.
package cm_pkg;
    localparam int WORD_W   = 32;
    localparam int PARCEL_W = WORD_W / 2;
    localparam int MAJOR_W  = 6;
    localparam int EXT_W    = 5;
    localparam int FORM_W   = 2;

    // How the parcel under decode is handled.
    typedef enum logic [1:0] {
        PK_WIDE  = 2'd0,
        PK_ENTRY = 2'd1,
        PK_SUST  = 2'd2,
        PK_PAD   = 2'd3
    } parcel_kind_e;

    localparam logic [FORM_W-1:0] FORM_ADDI  = 2'b00;
    localparam logic [FORM_W-1:0] FORM_ADDIS = 2'b01;

    // Decoded slot fields, without the immediate.
    typedef struct packed {
        logic               is16;
        logic               entry;
        logic [FORM_W-1:0]  form;
        logic [EXT_W-1:0]   ext;
        logic [MAJOR_W-1:0] major;
        logic [WORD_W-1:0]  raw;
    } slot_t;
endpackage

// File: rtl/cm_imm_expand.sv
// Expands the compressed immediate into a sign-extended IMM_W-bit value.
// Assumes IMM_W >= 11, so the widest form (shifted add-immediate) fits.
module cm_imm_expand #(
    parameter int IMM_W = 16
) (
    input  logic [cm_pkg::FORM_W-1:0] form,
    input  logic                      sign_bit,
    input  logic [6:0]                field,
    output logic [IMM_W-1:0]          imm
);
    import cm_pkg::*;

    localparam int PAD4  = IMM_W - 4;
    localparam int PAD8  = IMM_W - 8;
    localparam int PAD11 = IMM_W - 11;

    // Choose the extension width from the form code.
    always_comb begin
        if (form == FORM_ADDI) begin
            imm = {{PAD4{sign_bit}}, sign_bit, field[2:0]};
        end else if (form == FORM_ADDIS) begin
            imm = {{PAD11{sign_bit}}, sign_bit, field, 3'b000};
        end else begin
            imm = {{PAD8{sign_bit}}, sign_bit, field};
        end
    end
endmodule

// File: rtl/cm_parcel_buf.sv
// Holds one fetch word and a half pointer (upper half first).
// Assumes the consumer asserts take_word only at the upper half and
// take for a single parcel. A new word may load in the cycle the last
// parcel of the current word is consumed.
module cm_parcel_buf (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fetch_valid,
    input  logic [cm_pkg::WORD_W-1:0] fetch_data,
    output logic                      fetch_ready,
    input  logic                      take,
    input  logic                      take_word,
    output logic                      word_valid,
    output logic                      at_upper,
    output logic [cm_pkg::WORD_W-1:0] word
);
    import cm_pkg::*;

    logic              wvalid_q;
    logic              lower_q;
    logic [WORD_W-1:0] wbuf_q;
    logic              last_use;

    // Detect that the buffered word is used up this cycle.
    always_comb begin
        last_use    = take_word || (take && lower_q);
        fetch_ready = !wvalid_q || last_use;
    end

    // Load words, step the half pointer, release the word when used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wvalid_q <= 1'b0;
            lower_q  <= 1'b0;
            wbuf_q   <= '0;
        end else if (fetch_valid && fetch_ready) begin
            wvalid_q <= 1'b1;
            lower_q  <= 1'b0;
            wbuf_q   <= fetch_data;
        end else if (last_use) begin
            wvalid_q <= 1'b0;
            lower_q  <= 1'b0;
        end else if (take) begin
            lower_q  <= 1'b1;
        end
    end

    assign word_valid = wvalid_q;
    assign at_upper   = !lower_q;
    assign word       = wbuf_q;

    // A parcel is never consumed from an empty buffer.
    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (take || take_word) |-> wvalid_q) else $error("take on empty buffer"); // R3
    // The half pointer only moves forward from upper to lower within a word.
    AST_UPPER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lower_q) |-> $past(take) && !$past(fetch_valid && fetch_ready)) else $error("half order"); // R3
endmodule

// File: rtl/cm_parcel_dec.sv
// Classifies the current parcel and builds its slot fields.
// Assumes mode_c is the compressed-mode flag in effect for this parcel.
module cm_parcel_dec #(
    parameter int          IMM_W        = 16,
    parameter logic [4:0]  ENTRY_PREFIX = 5'b00010
) (
    input  logic [cm_pkg::WORD_W-1:0] word,
    input  logic                      at_upper,
    input  logic                      mode_c,
    output cm_pkg::parcel_kind_e      kind,
    output cm_pkg::slot_t             slot,
    output logic [IMM_W-1:0]          imm,
    output logic                      cont
);
    import cm_pkg::*;

    logic [PARCEL_W-1:0] parcel;
    logic [FORM_W-1:0]   form;
    logic [IMM_W-1:0]    imm_c;

    // Select the parcel and pull out the fields shared by all compressed parcels.
    always_comb begin
        parcel = at_upper ? word[WORD_W-1:PARCEL_W] : word[PARCEL_W-1:0];
        form   = {parcel[10], parcel[8]};
        cont   = parcel[9];
    end

    cm_imm_expand #(.IMM_W(IMM_W)) u_imm (
        .form     (form),
        .sign_bit (parcel[7]),
        .field    (parcel[6:0]),
        .imm      (imm_c)
    );

    // Classify the parcel: mode first, then the prefix, then alignment.
    always_comb begin
        if (mode_c)                            kind = PK_SUST;
        else if (parcel[15:11] == ENTRY_PREFIX) kind = PK_ENTRY;
        else if (at_upper)                     kind = PK_WIDE;
        else                                   kind = PK_PAD;
    end

    // Build the slot fields for the chosen kind.
    always_comb begin
        slot = '0;
        imm  = '0;
        case (kind)
            PK_WIDE: begin
                slot.major = word[WORD_W-1:WORD_W-MAJOR_W];
                slot.raw   = word;
            end
            PK_ENTRY: begin
                slot.is16  = 1'b1;
                slot.entry = 1'b1;
                slot.form  = form;
                slot.major = parcel[15:10];
                slot.raw   = {{PARCEL_W{1'b0}}, parcel};
                imm        = imm_c;
            end
            PK_SUST: begin
                slot.is16  = 1'b1;
                slot.form  = form;
                slot.ext   = parcel[15:11];
                slot.raw   = {{PARCEL_W{1'b0}}, parcel};
                imm        = imm_c;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cm_mode_ctx.sv
// Compressed-mode context register with trap clear and restore load.
// Assumes step is already blocked in trap and restore cycles.
module cm_mode_ctx (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic step_is16,
    input  logic step_cont,
    input  logic trap_pulse,
    input  logic restore_pulse,
    input  logic restore_mode,
    output logic mode_q
);
    // Update the mode: trap first, then restore, then the decoded parcel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (trap_pulse) begin
            mode_q <= 1'b0;
        end else if (restore_pulse) begin
            mode_q <= restore_mode;
        end else if (step) begin
            mode_q <= step_is16 && step_cont;
        end
    end

    // A trap always leaves the context in standard mode.
    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !mode_q) else $error("trap did not clear mode"); // R11
    // A restore without a trap loads the supplied value.
    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_pulse && !trap_pulse) |=> mode_q == $past(restore_mode)) else $error("restore mismatch"); // R12
    // No decode step happens in a trap or restore cycle.
    AST_NO_STEP_ON_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse || restore_pulse) |-> !step) else $error("step during context write"); // R11
endmodule

// File: rtl/cm_seq.sv
// Compressed-mode instruction stream sequencer (top).
// Takes fetch words, decodes one parcel or word per cycle into a
// registered output slot, and holds the compressed-mode context.
// Assumes fetch words are aligned and trap/restore are single-cycle pulses.
module cm_seq #(
    parameter int         IMM_W        = 16,
    parameter logic [4:0] ENTRY_PREFIX = 5'b00010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [31:0]      fetch_data,
    output logic             fetch_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_is16,
    output logic             out_entry,
    output logic [1:0]       out_form,
    output logic [4:0]       out_ext,
    output logic [5:0]       out_major,
    output logic [IMM_W-1:0] out_imm,
    output logic [31:0]      out_raw,
    input  logic             trap_pulse,
    input  logic             restore_pulse,
    input  logic             restore_mode,
    output logic             save_mode
);
    import cm_pkg::*;

    logic              word_valid;
    logic              at_upper;
    logic [WORD_W-1:0] word;
    logic              mode_q;
    parcel_kind_e      kind;
    slot_t             dec_slot;
    logic [IMM_W-1:0]  dec_imm;
    logic              dec_cont;
    logic              slot_free;
    logic              step;
    logic              emit;
    logic              take;
    logic              take_word;
    slot_t             slot_q;
    logic [IMM_W-1:0]  imm_q;
    logic              ovalid_q;

    cm_parcel_buf u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .fetch_ready (fetch_ready),
        .take        (take),
        .take_word   (take_word),
        .word_valid  (word_valid),
        .at_upper    (at_upper),
        .word        (word)
    );

    cm_parcel_dec #(.IMM_W(IMM_W), .ENTRY_PREFIX(ENTRY_PREFIX)) u_dec (
        .word     (word),
        .at_upper (at_upper),
        .mode_c   (mode_q),
        .kind     (kind),
        .slot     (dec_slot),
        .imm      (dec_imm),
        .cont     (dec_cont)
    );

    cm_mode_ctx u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (step),
        .step_is16     (dec_slot.is16),
        .step_cont     (dec_cont),
        .trap_pulse    (trap_pulse),
        .restore_pulse (restore_pulse),
        .restore_mode  (restore_mode),
        .mode_q        (mode_q)
    );

    // Decide whether a parcel advances this cycle and what it uses up.
    always_comb begin
        slot_free = !ovalid_q || out_ready;
        step      = word_valid && slot_free && !trap_pulse && !restore_pulse;
        emit      = step && (kind != PK_PAD);
        take      = step && (kind != PK_WIDE);
        take_word = step && (kind == PK_WIDE);
    end

    // Output slot register: load on emit, clear when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovalid_q <= 1'b0;
            slot_q   <= '0;
            imm_q    <= '0;
        end else if (emit) begin
            ovalid_q <= 1'b1;
            slot_q   <= dec_slot;
            imm_q    <= dec_imm;
        end else if (out_ready) begin
            ovalid_q <= 1'b0;
        end
    end

    assign out_valid = ovalid_q;
    assign out_is16  = slot_q.is16;
    assign out_entry = slot_q.entry;
    assign out_form  = slot_q.form;
    assign out_ext   = slot_q.ext;
    assign out_major = slot_q.major;
    assign out_imm   = imm_q;
    assign out_raw   = slot_q.raw;
    assign save_mode = mode_q;

    // A stalled slot keeps its contents.
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_raw) && $stable(out_imm) && $stable(out_is16)) else $error("slot changed under stall"); // R13
    // A 32-bit slot never carries an entry opcode.
    AST_WIDE_NOT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is16) |-> out_major[5:1] != ENTRY_PREFIX) else $error("wide slot with prefix"); // R2
    // The add-immediate form stays inside four signed bits.
    AST_ADDI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is16 && out_form == FORM_ADDI) |->
        ($signed(out_imm) >= $signed(IMM_W'(-8)) && $signed(out_imm) <= $signed(IMM_W'(7)))) else $error("addi range"); // R8
    // The shifted form is a multiple of eight.
    AST_ADDIS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is16 && out_form == FORM_ADDIS) |-> out_imm[2:0] == 3'b000) else $error("addis align"); // R9
    // The other forms stay inside eight signed bits.
    AST_SEXT8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is16 && out_form[1]) |->
        ($signed(out_imm) >= $signed(IMM_W'(-128)) && $signed(out_imm) <= $signed(IMM_W'(127)))) else $error("sext8 range"); // R10
endmodule

// File: tb/cm_seq_bench.sv
// Scoreboard bench: tests push expected slots, a monitor compares outputs.
module cm_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] PFX = 5'b00010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_data = '0;
    logic        fetch_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_is16, out_entry;
    logic [1:0]  out_form;
    logic [4:0]  out_ext;
    logic [5:0]  out_major;
    logic [15:0] out_imm;
    logic [31:0] out_raw;
    logic        trap_pulse = 1'b0, restore_pulse = 1'b0, restore_mode = 1'b0;
    logic        save_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        is16;
        logic        entry;
        logic [1:0]  form;
        logic [4:0]  ext;
        logic [5:0]  major;
        logic [15:0] imm;
        logic [31:0] raw;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    cm_seq u_cm_seq (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .fetch_ready(fetch_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_is16(out_is16), .out_entry(out_entry), .out_form(out_form), .out_ext(out_ext),
        .out_major(out_major), .out_imm(out_imm), .out_raw(out_raw),
        .trap_pulse(trap_pulse), .restore_pulse(restore_pulse),
        .restore_mode(restore_mode), .save_mode(save_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Parcel layout: {top5, form[1], cont, form[0], i2, field7}.
    function automatic logic [15:0] mkp(input logic [4:0] top, input logic [1:0] form,
                                        input logic cont, input logic i2, input logic [6:0] f);
        return {top, form[1], cont, form[0], i2, f};
    endfunction

    // Immediate value by form, from the requirement ranges.
    function automatic logic [15:0] exp_imm(input logic [1:0] form, input logic i2, input logic [6:0] f);
        int v;
        if (form == 2'b00)      v = int'(f[2:0]) - (i2 ? 8 : 0);      // R8
        else if (form == 2'b01) v = int'(f) * 8 - (i2 ? 1024 : 0);    // R9
        else                    v = int'(f) - (i2 ? 128 : 0);         // R10
        return 16'(v);
    endfunction

    task automatic exp_wide(input logic [31:0] w, input string tag);
        exp_t e;
        e = '0; e.major = w[31:26]; e.raw = w;
        expq.push_back(e); tagq.push_back(tag);
    endtask

    task automatic exp_c16(input logic [15:0] p, input logic entry, input string tag);
        exp_t e;
        e = '0; e.is16 = 1'b1; e.entry = entry; e.form = {p[10], p[8]};
        if (entry) e.major = p[15:10]; else e.ext = p[15:11];
        e.imm = exp_imm({p[10], p[8]}, p[7], p[6:0]);
        e.raw = {16'h0, p};
        expq.push_back(e); tagq.push_back(tag);
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_data = w;
        #2;
        while (!fetch_ready) begin @(negedge clk); #2; end
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Monitor: randomised ready, compare on handshake, check stall stability.
    logic [7:0]  lfsr = 8'hA5;
    logic        stall_prev = 1'b0;
    logic [31:0] raw_prev = '0;
    logic [15:0] imm_prev = '0;
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0] | lfsr[3];
            #1;
            if (rst_n && stall_prev) begin // R13
                check("R13 valid held", {63'h0, out_valid}, 64'h1);
                check("R13 raw held", {32'h0, out_raw}, {32'h0, raw_prev});
                check("R13 imm held", {48'h0, out_imm}, {48'h0, imm_prev});
            end
            stall_prev = rst_n && out_valid && !out_ready;
            raw_prev = out_raw; imm_prev = out_imm;
            if (rst_n && out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected slot actual=%0h expected=none", out_raw);
                end else begin
                    exp_t e;
                    string t;
                    e = expq.pop_front(); t = tagq.pop_front();
                    check({t, " is16"},  {63'h0, out_is16},  {63'h0, e.is16});
                    check({t, " entry"}, {63'h0, out_entry}, {63'h0, e.entry});
                    check({t, " form"},  {62'h0, out_form},  {62'h0, e.form});
                    check({t, " ext"},   {59'h0, out_ext},   {59'h0, e.ext});
                    check({t, " major"}, {58'h0, out_major}, {58'h0, e.major});
                    check({t, " imm"},   {48'h0, out_imm},   {48'h0, e.imm});
                    check({t, " raw"},   {32'h0, out_raw},   {32'h0, e.raw});
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w1, w2;
        logic [15:0] a, b;
        w1 = 32'h7C00_1234;
        w2 = 32'hA000_0001;
        repeat (3) @(negedge clk);
        #1;
        check("R1 out_valid", {63'h0, out_valid}, 64'h0);
        check("R1 fetch_ready", {63'h0, fetch_ready}, 64'h1);
        check("R1 save_mode", {63'h0, save_mode}, 64'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2: plain standard words.
        exp_wide(w1, "R2"); send_word(w1);
        exp_wide(w2, "R2"); send_word(w2);

        // R4 R3 R6 R8 R9: entry addi -1 continuing, then sustained addis -1024 ending.
        a = mkp(PFX, 2'b00, 1'b1, 1'b1, 7'h07);
        b = mkp(5'h1F, 2'b01, 1'b0, 1'b1, 7'h00);
        exp_c16(a, 1'b1, "R4"); exp_c16(b, 1'b0, "R6"); send_word({a, b});
        exp_wide(w1, "R6 back to standard"); send_word(w1);

        // R7 R10: entry +127 ending in upper half, lower padding dropped.
        a = mkp(PFX, 2'b11, 1'b0, 1'b0, 7'h7F);
        exp_c16(a, 1'b1, "R10"); send_word({a, 16'hFFFF});
        exp_wide(w2, "R7 after padding"); send_word(w2);

        // R4 R9 R10: two entries in one word, -128 and +1016.
        a = mkp(PFX, 2'b10, 1'b0, 1'b1, 7'h00);
        b = mkp(PFX, 2'b01, 1'b0, 1'b0, 7'h7F);
        exp_c16(a, 1'b1, "R10 min"); exp_c16(b, 1'b1, "R9 max"); send_word({a, b});

        // R5 R8: sustained parcel with prefix bits, run crossing into next word.
        a = mkp(PFX, 2'b00, 1'b1, 1'b0, 7'h07);
        b = mkp(PFX, 2'b10, 1'b1, 1'b1, 7'h7F);
        exp_c16(a, 1'b1, "R8 max"); exp_c16(b, 1'b0, "R5"); send_word({a, b});
        a = mkp(5'h03, 2'b11, 1'b1, 1'b0, 7'h10);
        b = mkp(5'h00, 2'b00, 1'b0, 1'b1, 7'h00);
        exp_c16(a, 1'b0, "R5 cross"); exp_c16(b, 1'b0, "R8 min"); send_word({a, b});
        exp_wide(w2, "R6 end of run"); send_word(w2);
        drain();

        // R11: enter and stay in compressed mode, then trap.
        a = mkp(PFX, 2'b00, 1'b1, 1'b0, 7'h01);
        b = mkp(5'h05, 2'b00, 1'b1, 1'b0, 7'h02);
        exp_c16(a, 1'b1, "R11 setup"); exp_c16(b, 1'b0, "R11 setup"); send_word({a, b});
        drain();
        check("R11 mode saved", {63'h0, save_mode}, 64'h1);
        @(negedge clk); trap_pulse = 1'b1; #1;
        check("R11 visible in trap cycle", {63'h0, save_mode}, 64'h1);
        @(posedge clk); #1; trap_pulse = 1'b0;
        @(negedge clk); #1;
        check("R11 cleared", {63'h0, save_mode}, 64'h0);
        exp_wide(w2, "R11 standard after trap"); send_word(w2);
        drain();

        // R12: restore compressed mode; a prefix-free word now decodes as parcels.
        @(negedge clk); restore_mode = 1'b1; restore_pulse = 1'b1;
        @(posedge clk); #1; restore_pulse = 1'b0; restore_mode = 1'b0;
        @(negedge clk); #1;
        check("R12 restored", {63'h0, save_mode}, 64'h1);
        a = mkp(5'h0F, 2'b10, 1'b0, 1'b0, 7'h00);
        exp_c16(a, 1'b0, "R12 sustained"); send_word({a, 16'hFFFF});
        exp_wide(w1, "R12 then standard"); send_word(w1);
        drain();
        check("R13 all slots delivered", 64'(expq.size()), 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule